// File: doc/BRIEF.md
# Interrupt Event Status Controller

This block gathers event pulses from six sources, five timer channel events and one counter overflow event, and turns them into sticky status bits that software can poll or take as one interrupt. Each source owns one raw status bit, which latches when the event arrives whatever the mask says. It also owns one mask bit. The bitwise AND of the two forms the masked status, and the OR of the masked status, registered, drives a single interrupt request.

Software reaches the block through a plain word-addressed register port with a combinational read path. The raw status, the mask and the masked status can be read back. Four write-one-to-act registers change state without a read-modify-write. One injects events as if hardware had raised them, one clears events, and two set or clear mask bits atomically. Injection goes through the same set path as a hardware event, so a diagnostic routine can exercise the whole interrupt chain.

Top module: `irq_event_ctrl`

## Requirements
- R1: Status bit i (i = 0..4) belongs to channel event i and bit 5 to the overflow event. Every readable register returns zero in bits 31:6, and write data in bits 31:6 has no effect.
- R2: A high level on `hw_evt_i[i]` during a clock edge sets raw status bit i (read at word address 0) from the next cycle on, whether or not mask bit i is set. The bit then holds until it is cleared.
- R3: The masked status (read at word address 2) always equals the bitwise AND of the mask (word address 1) and the raw status.
- R4: Writing to the event-set register (word address 3) sets each raw status bit whose write data bit is 1, from the next cycle on. Bits written 0 keep their value.
- R5: Writing to the event-clear register (word address 4) clears each raw status bit whose write data bit is 1, from the next cycle on. Bits written 0 keep their value.
- R6: Writing to the mask-set register (word address 5) sets the mask bits written 1. Writing to the mask-clear register (word address 6) clears the mask bits written 1. Bits written 0 are left unchanged by both registers.
- R7: After a synchronous active-low reset, the raw status, the mask, the masked status and `irq_o` are all zero.
- R8: If a hardware event and an event-clear write hit the same bit in the same cycle, the bit stays set.
- R9: `irq_o` is the OR of all masked status bits, registered: it shows one cycle later the value the masked status had in the previous cycle.
- R10: Word addresses 3 to 7 read back as zero. A write to word addresses 0, 1, 2 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_evt_i | input | 6 | Hardware event inputs, bits 0..4 channel events, bit 5 overflow |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | 1 = write, 0 = read, while selected |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected for a read |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
On every cycle the assertions check the sticky behaviour of each raw bit: it sets after an event or an injection, it clears only after a clear with no event in the same cycle, and otherwise it holds. They also check that the mask moves only where a set or clear bit was written, that at most one write strobe fires, that write-only and upper bits read as zero, and that every edge of the interrupt follows the masked status of the cycle before. Only the bench scenarios show that the address map lands on the right registers and that the readback of the masked status matches the AND of the mask and the raw status. They also cover the one-cycle lag of the interrupt after a mask change, and the combined effect of many mixed writes and events, which the reference model compares cycle by cycle.

// File: rtl/irq_stat_pkg.sv
// Package: shared constants and types of the interrupt event status controller.
// Assumes a word-addressed register port with three address bits.
package irq_stat_pkg;

    localparam int REG_ADDR_W = 3;

    // Word addresses of the register port; the bench and software rely on them.
    typedef enum logic [REG_ADDR_W-1:0] {
        ADR_RAW    = 3'd0,
        ADR_MASK   = 3'd1,
        ADR_MASKED = 3'd2,
        ADR_EVSET  = 3'd3,
        ADR_EVCLR  = 3'd4,
        ADR_MSET   = 3'd5,
        ADR_MCLR   = 3'd6,
        ADR_SPARE  = 3'd7
    } reg_addr_e;

    // One strobe per write-one-to-act register, at most one high per cycle.
    typedef struct packed {
        logic ev_set;
        logic ev_clr;
        logic m_set;
        logic m_clr;
    } wr_strobe_t;

endpackage

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Turns a register-port write into one of four action strobes plus the
// write bits that apply to the event sources. Assumes single-cycle writes
// that are qualified by sel and wr; writes to read-only addresses give no strobe.
module irq_reg_decode
    import irq_stat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output wr_strobe_t            strobe_o,
    output logic [NSRC-1:0]       wbits_o
);

    logic wr_en;

    // Purpose: qualify a write cycle.
    always_comb begin
        wr_en = sel_i && wr_i;
    end

    // Purpose: pick the action register the write is aimed at.
    always_comb begin
        strobe_o = '0;
        if (wr_en) begin
            unique case (reg_addr_e'(addr_i))
                ADR_EVSET: strobe_o.ev_set = 1'b1;
                ADR_EVCLR: strobe_o.ev_clr = 1'b1;
                ADR_MSET:  strobe_o.m_set  = 1'b1;
                ADR_MCLR:  strobe_o.m_clr  = 1'b1;
                default:   strobe_o        = '0;
            endcase
        end
    end

    // Purpose: only the low bits of the write data address a source.
    always_comb begin
        wbits_o = wdata_i[NSRC-1:0];
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe_o.ev_set, strobe_o.ev_clr, strobe_o.m_set, strobe_o.m_clr})) // R10
        else $error("more than one write strobe");

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && wr_i) |-> (strobe_o == '0)) // R10
        else $error("strobe without a write");

endmodule

// File: rtl/irq_status_bit.sv
// Module: irq_status_bit
// One sticky raw status bit. It is set by a hardware event or a software
// injection and cleared by a software clear. A hardware event in the same
// cycle as a clear wins. Assumes the inputs are synchronous to clk.
module irq_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic status_o
);

    logic status_q;
    logic status_d;

    // Purpose: next state with set sources above the clear.
    always_comb begin
        status_d = status_q;
        if (sw_clr_i) begin
            status_d = 1'b0;
        end
        if (hw_evt_i || sw_set_i) begin
            status_d = 1'b1;
        end
    end

    // Purpose: hold the sticky bit, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt_i |=> status_o) // R2
        else $error("event did not set status");

    AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> status_o) // R4
        else $error("injection did not set status");

    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && !hw_evt_i && !sw_set_i) |=> !status_o) // R5
        else $error("clear did not clear status");

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && hw_evt_i) |=> status_o) // R8
        else $error("clear won over event");

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_evt_i && !sw_set_i && !sw_clr_i) |=> $stable(status_o)) // R2
        else $error("status moved without cause");

endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Mask register changed only by atomic set and clear vectors. Assumes the
// set and clear vectors are never active in the same cycle (separate
// addresses); if they were, the clear would win.
module irq_mask_reg #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] mask_o
);

    logic [NSRC-1:0] mask_q;

    // Purpose: apply the set and clear bits, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_i) & ~clr_i;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((mask_o & $past(set_i)) == $past(set_i))) // R6
        else $error("mask set failed");

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((mask_o & $past(clr_i)) == '0)) // R6
        else $error("mask clear failed");

    AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((mask_o ^ $past(mask_o)) & ~($past(set_i) | $past(clr_i))) == '0)) // R6
        else $error("mask bit moved without a write");

endmodule

// File: rtl/irq_read_mux.sv
// Module: irq_read_mux
// Combinational readback of the raw status, mask and masked status. Write-only
// and spare addresses return zero, and so does any cycle that is not a read.
module irq_read_mux
    import irq_stat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]       raw_i,
    input  logic [NSRC-1:0]       mask_i,
    input  logic [NSRC-1:0]       masked_i,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int PAD_W = DATA_W - NSRC;

    logic [NSRC-1:0] pick;

    // Purpose: select the source vector for the addressed register.
    always_comb begin
        pick = '0;
        if (sel_i && !wr_i) begin
            unique case (reg_addr_e'(addr_i))
                ADR_RAW:    pick = raw_i;
                ADR_MASK:   pick = mask_i;
                ADR_MASKED: pick = masked_i;
                default:    pick = '0;
            endcase
        end
    end

    // Purpose: zero-extend to the bus width.
    always_comb begin
        rdata_o = {{PAD_W{1'b0}}, pick};
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:NSRC] == '0) // R1
        else $error("upper read bits not zero");

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && (addr_i >= REG_ADDR_W'(ADR_EVSET))) |-> (rdata_o == '0)) // R10
        else $error("write-only register read non-zero");

endmodule

// File: rtl/irq_event_ctrl.sv
// Module: irq_event_ctrl (top)
// Interrupt event status controller: NUM_CH channel events plus one overflow
// event latch into sticky raw bits, a mask gates them, and the OR of the
// masked status drives a registered interrupt. Assumes all inputs are
// synchronous to clk and the register port is a single-cycle access.
module irq_event_ctrl
    import irq_stat_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH:0]         hw_evt_i,
    input  logic                    bus_sel_i,
    input  logic                    bus_wr_i,
    input  logic [REG_ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    output logic [DATA_W-1:0]       bus_rdata_o,
    output logic                    irq_o
);

    localparam int NSRC = NUM_CH + 1;

    wr_strobe_t      strobe;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] mset_vec;
    logic [NSRC-1:0] mclr_vec;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] masked;
    logic            irq_q;

    irq_reg_decode #(
        .DATA_W (DATA_W),
        .NSRC   (NSRC)
    ) decode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .strobe_o (strobe),
        .wbits_o  (wbits)
    );

    // Purpose: spread the strobes over the per-source write bits.
    always_comb begin
        set_vec  = strobe.ev_set ? wbits : '0;
        clr_vec  = strobe.ev_clr ? wbits : '0;
        mset_vec = strobe.m_set  ? wbits : '0;
        mclr_vec = strobe.m_clr  ? wbits : '0;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_status_bit status_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_evt_i (hw_evt_i[g]),
            .sw_set_i (set_vec[g]),
            .sw_clr_i (clr_vec[g]),
            .status_o (raw[g])
        );
    end

    irq_mask_reg #(
        .NSRC (NSRC)
    ) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mset_vec),
        .clr_i  (mclr_vec),
        .mask_o (mask)
    );

    // Purpose: gate the raw status with the mask.
    always_comb begin
        masked = raw & mask;
    end

    // Purpose: register the combined interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked;
        end
    end

    assign irq_o = irq_q;

    irq_read_mux #(
        .DATA_W (DATA_W),
        .NSRC   (NSRC)
    ) rmux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .raw_i    (raw),
        .mask_i   (mask),
        .masked_i (masked),
        .rdata_o  (bus_rdata_o)
    );

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(masked) != '0)) // R9
        else $error("irq rose with no masked status");

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(masked) == '0)) // R9
        else $error("irq fell with masked status pending");

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (masked != '0) |=> irq_o) // R9
        else $error("irq missing for masked status");

endmodule

// File: tb/irq_event_ctrl_tb_top.sv
// Bench: behavioural reference model stepped on every clock, compared at each
// negative edge, plus directed checks with expected values from the requirements.
module irq_event_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hw_evt = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Reference state.
    bit [5:0] m_raw = '0;
    bit [5:0] m_mask = '0;
    bit       m_irq = 1'b0;

    always #2 clk = ~clk;

    irq_event_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_evt_i    (hw_evt),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit any;
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_irq = 1'b0;
        end else begin
            any = 1'b0;
            for (int i = 0; i < 6; i++) if (m_raw[i] && m_mask[i]) any = 1'b1;
            m_irq = any;
            for (int i = 0; i < 6; i++) begin
                if (sel && wr && addr == 3'd3 && wdata[i]) m_raw[i] = 1'b1;
                if (sel && wr && addr == 3'd4 && wdata[i] && !hw_evt[i]) m_raw[i] = 1'b0;
                if (hw_evt[i]) m_raw[i] = 1'b1;
                if (sel && wr && addr == 3'd5 && wdata[i]) m_mask[i] = 1'b1;
                if (sel && wr && addr == 3'd6 && wdata[i]) m_mask[i] = 1'b0;
            end
        end
    end

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        if (sel && !wr) begin
            case (addr)
                3'd0: v[5:0] = m_raw;
                3'd1: v[5:0] = m_mask;
                3'd2: v[5:0] = m_raw & m_mask;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R6";
            3'd2: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, then compare against the model.
    task automatic cyc(bit s, bit w, logic [2:0] a, logic [31:0] d, logic [5:0] h);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; hw_evt = h;
        #1;
        if (cmp_en) begin
            chk({tag_of(a), " model readback"}, rdata, model_rd());
            chk("R9 model irq", {31'd0, irq}, {31'd0, m_irq});
        end
    endtask

    task automatic rd(logic [2:0] a);
        cyc(1'b1, 1'b0, a, '0, '0);
    endtask

    task automatic wrr(logic [2:0] a, logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, '0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R7 reset state
        rd(3'd0); chk("R7 raw after reset", rdata, 32'h0);
        rd(3'd1); chk("R7 mask after reset", rdata, 32'h0);
        rd(3'd2); chk("R7 masked after reset", rdata, 32'h0);
        chk("R7 irq after reset", {31'd0, irq}, 32'h0);

        // R2 unmasked event latches in raw only
        cyc(1'b1, 1'b0, 3'd0, '0, 6'b000100);
        rd(3'd0); chk("R2 event latches raw", rdata, 32'h04);
        rd(3'd2); chk("R3 masked zero while mask clear", rdata, 32'h0);
        chk("R9 no irq while masked", {31'd0, irq}, 32'h0);

        // R6 mask set, R9 one-cycle lag
        wrr(3'd5, 32'h04);
        rd(3'd2); chk("R3 masked after mask set", rdata, 32'h04);
        chk("R9 irq lags masked status", {31'd0, irq}, 32'h0);
        rd(3'd2); chk("R9 irq asserted", {31'd0, irq}, 32'h1);

        // R6 zero writes have no effect
        wrr(3'd5, 32'h0);
        wrr(3'd6, 32'h0);
        rd(3'd1); chk("R6 zero writes leave mask", rdata, 32'h04);

        // R4 injection
        wrr(3'd3, 32'h21);
        rd(3'd0); chk("R4 injected raw", rdata, 32'h25);
        rd(3'd2); chk("R3 masked after injection", rdata, 32'h04);
        rd(3'd3); chk("R10 event-set reads zero", rdata, 32'h0);
        rd(3'd6); chk("R10 mask-clear reads zero", rdata, 32'h0);

        // R5 clear
        wrr(3'd4, 32'h01);
        rd(3'd0); chk("R5 clear one bit", rdata, 32'h24);

        // R8 event beats clear
        cyc(1'b1, 1'b1, 3'd4, 32'h20, 6'b100000);
        rd(3'd0); chk("R8 event wins over clear", rdata, 32'h24);

        wrr(3'd4, 32'h24);
        rd(3'd0); chk("R5 clear all set bits", rdata, 32'h0);
        wrr(3'd6, 32'h04);
        rd(3'd1); chk("R6 mask clear", rdata, 32'h0);
        rd(3'd1); chk("R9 irq dropped", {31'd0, irq}, 32'h0);

        // R1 upper bits
        wrr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0); chk("R1 full-word inject reads six bits", rdata, 32'h3F);
        wrr(3'd0, 32'h0);
        wrr(3'd2, 32'h0);
        wrr(3'd7, 32'hFFFF_FFFF);
        rd(3'd0); chk("R10 writes to read-only ignored", rdata, 32'h3F);
        rd(3'd1); chk("R10 mask untouched by read-only writes", rdata, 32'h0);
        wrr(3'd5, 32'hFFFF_FFC0);
        rd(3'd1); chk("R1 upper write bits ignored", rdata, 32'h0);
        wrr(3'd5, 32'h3F);
        rd(3'd2); chk("R3 all masked", rdata, 32'h3F);
        rd(3'd2); chk("R9 irq with all masked", {31'd0, irq}, 32'h1);

        cyc(1'b1, 1'b1, 3'd4, 32'h3F, 6'b001000);
        rd(3'd0); chk("R8 event survives full clear", rdata, 32'h08);
        rd(3'd2); chk("R3 masked follows raw", rdata, 32'h08);

        // Mixed traffic against the model
        lfsr = 32'hACE1_2357;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[0], lfsr[1] & lfsr[2], lfsr[5:3], {lfsr[31:8], 2'b00, lfsr[13:8]},
                (lfsr[6] && lfsr[7]) ? lfsr[19:14] : 6'b0);
        end

        cyc(1'b0, 1'b0, '0, '0, '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule